// File: doc/BRIEF.md
# Register Redirection Table Loader

This block keeps the per-register remapping state that a vector-capable core looks up when a scalar-looking instruction names a register. Up to four remap entries arrive together with an entry count and a format select. Each entry is either a full 16-bit word or a compact 8-bit byte. The block widens compact entries to the full form, then writes each entry into one of two directly indexed 32-row tables, one for integer registers and one for floating-point registers. The row is chosen by the key register carried in the entry. After loading, no associative search is needed: a lookup addresses the row by register number and type.

A load is accepted when the block is idle. Entries are written one per cycle in slot order, so a later slot overwrites an earlier one that has the same key and type. A clear input drops every enabled flag in both tables. A lookup returns its result one cycle after it is issued. A row that was never enabled passes the register number through unchanged and reports it as scalar.

Top module: `regmap_loader`

## Requirements
- R1: After synchronous reset, `ld_busy_o` and `rd_valid_o` are 0, and every row of both tables reads as disabled.
- R2: In full format (`ld_fmt8_i`=0), slot k is `ld_entries_i[16k+15:16k]`. Bit 15 is is-vector, bits 14..8 are the redirected index, bit 7 is the type, bits 6..5 are the element width and bits 4..0 are the key. A loaded row returns enabled=1 together with that entry's is-vector, width and index.
- R3: In compact format (`ld_fmt8_i`=1), slot k is `ld_entries_i[8k+7:8k]`. Bit 7 is the type, bits 6..5 are the element width and bits 4..0 are the register number n. The entry is written with is-vector=1, redirected index n<<2 (7 bits) and key n.
- R4: Type 0 writes the integer table and type 1 writes the floating-point table. A lookup with `lk_fp_i`=t reads only table t, so an entry of the other type does not affect it.
- R5: A lookup of a disabled row returns enabled=0, is-vector=0, width=0 and index equal to the looked-up register number.
- R6: A `clr_i` pulse disables every row of both tables. When it coincides with the acceptance of a load, the rows from that load end up enabled.
- R7: When two slots of one load share key and type, the higher-numbered slot's fields remain.
- R8: Only slots 0..c-1 are written, where c is `ld_count_i` limited to 4. A count of 0 writes nothing and does not raise busy.
- R9: An accepted load holds `ld_busy_o` high for exactly c cycles. A `ld_valid_i` seen while busy is ignored.
- R10: `rd_valid_o` is high exactly in the cycle after a cycle with `lk_valid_i` high, and it carries that lookup's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Disable all rows of both tables |
| ld_valid_i | input | 1 | Load request strobe |
| ld_fmt8_i | input | 1 | 1: compact 8-bit entries, 0: full 16-bit entries |
| ld_count_i | input | 3 | Number of entries in the load |
| ld_entries_i | input | 64 | Entry slots, slot 0 in the low bits |
| ld_busy_o | output | 1 | Load in progress |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_fp_i | input | 1 | Lookup table select, 1 = floating point |
| lk_reg_i | input | 5 | Register number to look up |
| rd_valid_o | output | 1 | Lookup result valid |
| rd_en_o | output | 1 | Row enabled |
| rd_vec_o | output | 1 | Row is vector |
| rd_ew_o | output | 2 | Element width |
| rd_idx_o | output | 7 | Redirected register index |

## Verification
The assertions assume that lookups are never issued while `ld_busy_o` is high, because a row being written in the same cycle reads back its old contents. The assertions also assume that reset is held for at least one clock edge before any other input is used. The stimulus waits for busy to fall before every lookup and releases reset only on a falling edge. Requests sent during a load are made on purpose and only to check that they are dropped.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  localparam int KEY_W = 5;
  localparam int IDX_W = 7;
  localparam int EW_W  = 2;
  localparam int FULL_W = 16;
  localparam int CMPT_W = 8;
  localparam int ROW_W = 1 + IDX_W + EW_W;
  localparam int ADDR_W = KEY_W + 1;

  typedef struct packed {
    logic             vec;
    logic [IDX_W-1:0] idx;
    logic             fp;
    logic [EW_W-1:0]  ew;
    logic [KEY_W-1:0] key;
  } rm_ent_t;

  typedef struct packed {
    logic             vec;
    logic [IDX_W-1:0] idx;
    logic [EW_W-1:0]  ew;
  } rm_row_t;
endpackage

// File: rtl/regmap_widen.sv
module regmap_widen
  import regmap_pkg::*;
#(
  parameter int N_SLOTS = 4
) (
  input  logic                       fmt8_i,
  input  logic [N_SLOTS*FULL_W-1:0]  raw_i,
  output rm_ent_t [N_SLOTS-1:0]      ent_o
);
  localparam int PAD_W = IDX_W - KEY_W;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic [CMPT_W-1:0] byte_w;
    assign byte_w = raw_i[g*CMPT_W +: CMPT_W];
    always_comb begin
      if (fmt8_i) begin
        ent_o[g].vec = 1'b1;
        ent_o[g].idx = {byte_w[KEY_W-1:0], {PAD_W{1'b0}}};
        ent_o[g].fp  = byte_w[7];
        ent_o[g].ew  = byte_w[6:5];
        ent_o[g].key = byte_w[KEY_W-1:0];
      end else begin
        ent_o[g] = rm_ent_t'(raw_i[g*FULL_W +: FULL_W]);
      end
    end
  end
endmodule

// File: rtl/regmap_seq.sv
module regmap_seq
  import regmap_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int CNT_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_valid_i,
  input  logic [CNT_W-1:0]      ld_count_i,
  input  rm_ent_t [N_SLOTS-1:0] ent_i,
  output logic                  busy_o,
  output logic                  we_o,
  output logic [ADDR_W-1:0]     wa_o,
  output rm_row_t               wd_o
);
  localparam int PTR_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  rm_ent_t [N_SLOTS-1:0] held;
  logic [PTR_W-1:0]      ptr;
  logic [PTR_W-1:0]      last;
  logic [CNT_W-1:0]      eff;
  rm_ent_t               cur;

  always_comb begin
    if (ld_count_i > CNT_W'(N_SLOTS)) eff = CNT_W'(N_SLOTS);
    else                              eff = ld_count_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      ptr    <= '0;
      last   <= '0;
    end else if (!busy_o) begin
      if (ld_valid_i && eff != '0) begin
        busy_o <= 1'b1;
        ptr    <= '0;
        last   <= PTR_W'(eff - 1'b1);
      end
    end else begin
      ptr <= ptr + 1'b1;
      if (ptr == last) busy_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!busy_o && ld_valid_i) held <= ent_i;
  end

  assign cur      = held[ptr];
  assign we_o     = busy_o;
  assign wa_o     = {cur.fp, cur.key};
  assign wd_o.vec = cur.vec;
  assign wd_o.idx = cur.idx;
  assign wd_o.ew  = cur.ew;

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> ptr <= last);  // R8
  AST_ZERO_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && ld_valid_i && ld_count_i == '0) |=> !busy_o);  // R8
  AST_BUSY_REQ_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && ld_valid_i) |=> $stable(last));  // R9
endmodule

// File: rtl/regmap_table.sv
module regmap_table
  import regmap_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  rm_row_t       wd_i,
  input  logic          re_i,
  input  logic [AW-1:0] ra_i,
  output rm_row_t       rd_o,
  output logic          rflag_o
);
  localparam int DEPTH = 1 << AW;

  rm_row_t          mem [DEPTH];
  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
    if (re_i) rd_o <= mem[ra_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      rflag_o <= 1'b0;
    end else begin
      if (clr_i) flags <= '0;
      if (we_i)  flags[wa_i] <= 1'b1;
      if (re_i)  rflag_o <= flags[ra_i];
    end
  end

  AST_CLEAR_DROPS_ALL: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !we_i) |=> flags == '0);  // R6
  AST_WRITE_ENABLES_ROW: assert property (@(posedge clk) disable iff (rst)
    we_i |=> flags[$past(wa_i)]);  // R2
endmodule

// File: rtl/regmap_loader.sv
module regmap_loader
  import regmap_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int CNT_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_i,
  input  logic                      ld_valid_i,
  input  logic                      ld_fmt8_i,
  input  logic [CNT_W-1:0]          ld_count_i,
  input  logic [N_SLOTS*FULL_W-1:0] ld_entries_i,
  output logic                      ld_busy_o,
  input  logic                      lk_valid_i,
  input  logic                      lk_fp_i,
  input  logic [KEY_W-1:0]          lk_reg_i,
  output logic                      rd_valid_o,
  output logic                      rd_en_o,
  output logic                      rd_vec_o,
  output logic [EW_W-1:0]           rd_ew_o,
  output logic [IDX_W-1:0]          rd_idx_o
);
  rm_ent_t [N_SLOTS-1:0] wide;
  logic                  we;
  logic [ADDR_W-1:0]     wa;
  rm_row_t               wd;
  rm_row_t               row_q;
  logic                  flag_q;
  logic [KEY_W-1:0]      reg_q;

  regmap_widen #(.N_SLOTS(N_SLOTS)) u_widen (
    .fmt8_i (ld_fmt8_i),
    .raw_i  (ld_entries_i),
    .ent_o  (wide)
  );

  regmap_seq #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ld_valid_i (ld_valid_i),
    .ld_count_i (ld_count_i),
    .ent_i      (wide),
    .busy_o     (ld_busy_o),
    .we_o       (we),
    .wa_o       (wa),
    .wd_o       (wd)
  );

  regmap_table #(.AW(ADDR_W)) u_tab (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .we_i    (we),
    .wa_i    (wa),
    .wd_i    (wd),
    .re_i    (lk_valid_i),
    .ra_i    ({lk_fp_i, lk_reg_i}),
    .rd_o    (row_q),
    .rflag_o (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      reg_q      <= '0;
    end else begin
      rd_valid_o <= lk_valid_i;
      if (lk_valid_i) reg_q <= lk_reg_i;
    end
  end

  assign rd_en_o  = flag_q;
  assign rd_vec_o = flag_q & row_q.vec;
  assign rd_ew_o  = flag_q ? row_q.ew : '0;
  assign rd_idx_o = flag_q ? row_q.idx : {{(IDX_W-KEY_W){1'b0}}, reg_q};

  AST_RESULT_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lk_valid_i |=> rd_valid_o);  // R10
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
    !lk_valid_i |=> !rd_valid_o);  // R10
  AST_DISABLED_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_en_o) |-> rd_idx_o == {{(IDX_W-KEY_W){1'b0}}, $past(lk_reg_i)});  // R5
endmodule

// File: tb/sim_regmap_loader.sv
`timescale 1ns/1ps
module sim_regmap_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_i = 1'b0, ld_valid_i = 1'b0, ld_fmt8_i = 1'b0;
  logic [2:0]  ld_count_i = '0;
  logic [63:0] ld_entries_i = '0;
  logic        ld_busy_o;
  logic        lk_valid_i = 1'b0, lk_fp_i = 1'b0;
  logic [4:0]  lk_reg_i = '0;
  logic        rd_valid_o, rd_en_o, rd_vec_o;
  logic [1:0]  rd_ew_o;
  logic [6:0]  rd_idx_o;

  always #2.5 clk = ~clk;

  regmap_loader u0 (.*);

  int errors = 0, checks = 0;
  typedef struct { logic [10:0] exp; string tag; } item_t;
  item_t q[$];

  bit         m_en  [64];
  logic       m_vec [64];
  logic [1:0] m_ew  [64];
  logic [6:0] m_idx [64];

  function automatic logic [15:0] e16(logic v, logic [6:0] idx, logic fp, logic [1:0] ew, logic [4:0] key);
    return {v, idx, fp, ew, key};
  endfunction

  function automatic logic [7:0] e8(logic fp, logic [1:0] ew, logic [4:0] n);
    return {fp, ew, n};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) m_en[i] = 0;
  endtask

  task automatic model_load(input logic fmt8, input int cnt, input logic [63:0] d);
    int c;
    c = (cnt > 4) ? 4 : cnt;
    for (int k = 0; k < c; k++) begin
      logic v; logic [6:0] ix; logic fp; logic [1:0] ew; logic [4:0] key;
      if (fmt8) begin
        v = 1; fp = d[8*k+7]; ew = d[8*k+5 +: 2]; key = d[8*k +: 5]; ix = {key, 2'b00};
      end else begin
        v = d[16*k+15]; ix = d[16*k+8 +: 7]; fp = d[16*k+7]; ew = d[16*k+5 +: 2]; key = d[16*k +: 5];
      end
      m_en[{fp, key}] = 1; m_vec[{fp, key}] = v; m_ew[{fp, key}] = ew; m_idx[{fp, key}] = ix;
    end
  endtask

  task automatic load(input logic fmt8, input int cnt, input logic [63:0] d, input logic with_clr);
    int n;
    @(negedge clk);
    ld_valid_i = 1; ld_fmt8_i = fmt8; ld_count_i = 3'(cnt); ld_entries_i = d; clr_i = with_clr;
    if (with_clr) model_clear();
    model_load(fmt8, cnt, d);
    @(negedge clk);
    ld_valid_i = 0; clr_i = 0;
    n = 0;
    while (ld_busy_o && n < 20) begin n++; @(negedge clk); end
    chk("R9 busy cycles", n, (cnt > 4) ? 4 : cnt);
  endtask

  task automatic lookup(input logic fp, input logic [4:0] r, input string tag);
    item_t it;
    lk_valid_i = 1; lk_fp_i = fp; lk_reg_i = r;
    if (m_en[{fp, r}]) it.exp = {1'b1, m_vec[{fp, r}], m_ew[{fp, r}], m_idx[{fp, r}]};
    else               it.exp = {1'b0, 1'b0, 2'b00, 2'b00, r};
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    lk_valid_i = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected result actual=1 expected=0");
      end else begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, {21'b0, rd_en_o, rd_vec_o, rd_ew_o, rd_idx_o}, {21'b0, it.exp});
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 busy after reset", ld_busy_o, 0);
    chk("R1 rd_valid after reset", rd_valid_o, 0);
    @(negedge clk);
    lookup(0, 5'd3, "R1 int row disabled");
    lookup(1, 5'd31, "R1 fp row disabled");

    // R2 and R4: full format, int and fp with the same key
    load(0, 3, {16'h0, e16(1, 7'd127, 0, 2'd3, 5'd31), e16(0, 7'h12, 1, 2'd1, 5'd3),
                e16(1, 7'h45, 0, 2'd2, 5'd3)}, 0);
    lookup(0, 5'd3, "R2 int key 3");
    lookup(1, 5'd3, "R4 fp key 3");
    lookup(0, 5'd31, "R2 int key 31");
    lookup(1, 5'd31, "R4 fp key 31 untouched");
    lookup(0, 5'd4, "R5 disabled passthru");

    // R8: zero count, partial count, oversize count
    load(0, 0, {4{e16(1, 7'd1, 0, 2'd1, 5'd9)}}, 0);
    lookup(0, 5'd9, "R8 count zero writes nothing");
    load(0, 2, {e16(1, 7'd4, 1, 2'd0, 5'd21), e16(1, 7'd3, 1, 2'd0, 5'd20),
                e16(1, 7'd2, 1, 2'd0, 5'd11), e16(1, 7'd1, 1, 2'd0, 5'd10)}, 0);
    lookup(1, 5'd10, "R8 slot 0 written");
    lookup(1, 5'd11, "R8 slot 1 written");
    lookup(1, 5'd20, "R8 slot 2 skipped");
    lookup(1, 5'd21, "R8 slot 3 skipped");
    load(0, 7, {e16(0, 7'd44, 0, 2'd3, 5'd15), e16(0, 7'd43, 0, 2'd2, 5'd14),
                e16(0, 7'd42, 0, 2'd1, 5'd13), e16(0, 7'd41, 0, 2'd0, 5'd12)}, 0);
    lookup(0, 5'd12, "R8 over count slot 0");
    lookup(0, 5'd15, "R8 over count slot 3");

    // R3: compact format
    load(1, 4, {32'hFFFF_FFFF, e8(1, 2'd2, 5'd9), e8(0, 2'd0, 5'd0),
                e8(1, 2'd3, 5'd31), e8(0, 2'd1, 5'd5)}, 0);
    lookup(0, 5'd5, "R3 compact int 5");
    lookup(1, 5'd31, "R3 compact fp 31");
    lookup(0, 5'd0, "R3 compact int 0");
    lookup(1, 5'd9, "R3 compact fp 9");

    // R7: duplicate key, higher slot wins
    load(0, 3, {16'h0, e16(0, 7'd20, 0, 2'd2, 5'd7), e16(1, 7'd99, 1, 2'd1, 5'd7),
                e16(1, 7'd10, 0, 2'd1, 5'd7)}, 0);
    lookup(0, 5'd7, "R7 int key 7 last slot");
    lookup(1, 5'd7, "R7 fp key 7 distinct");

    // R6: clear, then clear together with a load
    @(negedge clk); clr_i = 1; model_clear();
    @(negedge clk); clr_i = 0;
    lookup(0, 5'd3, "R6 cleared int 3");
    lookup(1, 5'd31, "R6 cleared fp 31");
    lookup(0, 5'd7, "R6 cleared int 7");
    load(0, 1, {48'h0, e16(1, 7'd77, 1, 2'd2, 5'd1)}, 0);
    load(0, 1, {48'h0, e16(1, 7'd66, 0, 2'd1, 5'd2)}, 1);
    lookup(0, 5'd2, "R6 load with clear kept");
    lookup(1, 5'd1, "R6 older row cleared");

    // R9: request while busy is dropped
    @(negedge clk);
    ld_valid_i = 1; ld_fmt8_i = 0; ld_count_i = 3'd4;
    ld_entries_i = {4{e16(1, 7'd5, 0, 2'd1, 5'd25)}};
    model_load(0, 4, ld_entries_i);
    @(negedge clk);
    ld_entries_i = {4{e16(1, 7'd6, 1, 2'd1, 5'd26)}};
    @(negedge clk);
    ld_valid_i = 0;
    while (ld_busy_o) @(negedge clk);
    @(negedge clk);
    chk("R9 idle after load", ld_busy_o, 0);
    lookup(0, 5'd25, "R9 accepted load");
    lookup(1, 5'd26, "R9 busy request dropped");

    repeat (3) @(negedge clk);
    chk("R10 all results returned", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule